// File: doc/BRIEF.md
# SDRAM Command Mode Engine

This block turns one command word into the pin activity an SDRAM needs outside normal reads and writes: the clock-enable line, one chip select per device, the row/column/write strobes and the address bus. Software or a sequencer writes a word with a mode code, a pair of target bits, a refresh repeat count and mode-register data. The engine places the command on the pins for one cycle. It then waits the programmed number of cycles and lowers its busy flag when the memory may accept the next command.

The power-up flow is a series of such words in this order: enable the clock, wait out the start-up time, precharge all banks, issue eight auto-refreshes from one word, then load the mode register. The cycle limits between commands are row precharge time (tRP), row cycle time (tRC) and mode-register set time (tMRD). Each arrives on an input as its cycle count minus one.

Top module: `sdram_cmd_engine`

## Requirements
- R1: After reset, CKE is low, both chip selects are high, RAS/CAS/WE are high, the address is zero, and busy and overrun are low.
- R2: Command word fields are: mode in bits [2:0], target bit for chip select 0 in bit 3, target bit for chip select 1 in bit 4, refresh count in bits [8:5], and mode data in bits [21:9]. A set target bit pulls its chip select low. With both bits set, both chip selects go low in the same cycle.
- R3: Mode 2 (precharge all) appears one cycle after the accepting edge with RAS=0, CAS=1, WE=0, address bit 10 high and all other address bits low. Busy stays high for trp_m1+1 cycles.
- R4: Mode 3 (auto-refresh) issues N refreshes with RAS=0, CAS=0, WE=1, where N is the count field and a count of 0 gives one refresh. Successive refreshes start exactly trc_m1+1 cycles apart, and busy lasts N*(trc_m1+1) cycles.
- R5: Mode 4 (load mode) drives RAS=0, CAS=0, WE=0, puts the data field on the address bus and drives the bank bus to zero. Busy lasts tmrd_m1+1 cycles.
- R6: Mode 1 raises CKE from the cycle after acceptance. It asserts no chip select and keeps busy high for one cycle.
- R7: Mode 6 (power-down) lowers CKE without any chip select. Mode 5 (self-refresh) issues the refresh encoding with CKE low in the same cycle and keeps busy high for trc_m1+1 cycles. Power-down keeps busy high for one cycle.
- R8: Mode 0 (normal) asserts no chip select, leaves CKE unchanged and keeps busy high for one cycle.
- R9: Whenever busy is low, and on every busy cycle that is not a command cycle, both chip selects are high and RAS/CAS/WE are high.
- R10: A write while busy is high is discarded. It produces no pin activity and sets overrun, which then stays high until reset.
- R11: A write with both target bits clear, or with mode 7, is dropped. Busy does not rise, no pins move and overrun does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_wr | input | 1 | Command word write strobe |
| cmd_word | input | 22 | Command word |
| trc_m1 | input | 4 | Row cycle time minus one |
| trp_m1 | input | 4 | Precharge time minus one |
| tmrd_m1 | input | 4 | Mode-register set time minus one |
| busy | output | 1 | Command in progress |
| overrun | output | 1 | Sticky: write arrived while busy |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Chip selects, active low |
| sd_ras_n | output | 1 | Row strobe, active low |
| sd_cas_n | output | 1 | Column strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_addr | output | 13 | Address bus |
| sd_ba | output | 2 | Bank address |

## Verification
The bench walks the power-up order and then the low-power modes. For each command it counts the chip-select pulses, the gap between them and the busy length. An off-by-one in the minus-one timing shows up as a busy length one cycle off. A refresh count that is mishandled issues seven, nine or zero pulses instead of eight, or issues none for a count of zero. Setting tRC to one cycle demands truly back-to-back refreshes, which a design that inserts a NOP between repeats cannot give. A write during a refresh burst must neither inject a precharge between the refreshes nor be lost without raising overrun. A word with no target bits, or one carrying the reserved code, must not raise busy.

// File: rtl/sdcmd_pkg.sv
package sdcmd_pkg;

  typedef enum logic [2:0] {
    MD_NORMAL = 3'd0,
    MD_CKE_ON = 3'd1,
    MD_PALL   = 3'd2,
    MD_AREF   = 3'd3,
    MD_LMR    = 3'd4,
    MD_SREF   = 3'd5,
    MD_PDOWN  = 3'd6,
    MD_RSVD   = 3'd7
  } mode_e;

  typedef enum logic [1:0] {
    CKE_KEEP = 2'd0,
    CKE_SET  = 2'd1,
    CKE_CLR  = 2'd2
  } cke_act_e;

  typedef enum logic [1:0] {
    WT_NONE = 2'd0,
    WT_RP   = 2'd1,
    WT_RC   = 2'd2,
    WT_MRD  = 2'd3
  } wait_sel_e;

  typedef struct packed {
    logic ras_n;
    logic cas_n;
    logic we_n;
  } rcw_t;

  localparam rcw_t RCW_NOP  = 3'b111;
  localparam rcw_t RCW_PALL = 3'b010;
  localparam rcw_t RCW_REF  = 3'b001;
  localparam rcw_t RCW_LMR  = 3'b000;

endpackage

// File: rtl/sdcmd_decode.sv
module sdcmd_decode
  import sdcmd_pkg::*;
#(
  parameter int AW     = 13,
  parameter int CNT_W  = 4,
  parameter int AP_BIT = 10
) (
  input  logic [2:0]       mode_i,
  input  logic [1:0]       tgt_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic [AW-1:0]    data_i,
  output logic             ok_o,
  output logic             strobe_o,
  output rcw_t             rcw_o,
  output cke_act_e         cke_o,
  output wait_sel_e        wsel_o,
  output logic [AW-1:0]    addr_o,
  output logic [CNT_W-1:0] reps_o
);

  localparam logic [AW-1:0] ADDR_AP = AW'(1) << AP_BIT;

  mode_e md;
  assign md = mode_e'(mode_i);

  always_comb begin
    ok_o     = (tgt_i != 2'b00) && (md != MD_RSVD);
    strobe_o = 1'b0;
    rcw_o    = RCW_NOP;
    cke_o    = CKE_KEEP;
    wsel_o   = WT_NONE;
    addr_o   = '0;
    reps_o   = CNT_W'(1);
    case (md)
      MD_CKE_ON: cke_o = CKE_SET;
      MD_PDOWN:  cke_o = CKE_CLR;
      MD_PALL: begin
        strobe_o = 1'b1;
        rcw_o    = RCW_PALL;
        addr_o   = ADDR_AP;
        wsel_o   = WT_RP;
      end
      MD_AREF: begin
        strobe_o = 1'b1;
        rcw_o    = RCW_REF;
        wsel_o   = WT_RC;
        reps_o   = (cnt_i == '0) ? CNT_W'(1) : cnt_i;
      end
      MD_LMR: begin
        strobe_o = 1'b1;
        rcw_o    = RCW_LMR;
        addr_o   = data_i;
        wsel_o   = WT_MRD;
      end
      MD_SREF: begin
        strobe_o = 1'b1;
        rcw_o    = RCW_REF;
        cke_o    = CKE_CLR;
        wsel_o   = WT_RC;
      end
      default: ;
    endcase
  end

endmodule

// File: rtl/sdcmd_timer.sv
module sdcmd_timer #(
  parameter int TW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [TW-1:0] load_val_i,
  output logic          zero_o
);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? load_val_i : (cnt_q - 1'b1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign zero_o = (cnt_q == '0);

  // R4: an unloaded wait drains by exactly one per cycle
  p_timer_drain_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/sdram_cmd_engine.sv
module sdram_cmd_engine
  import sdcmd_pkg::*;
#(
  parameter int AW     = 13,
  parameter int BA_W   = 2,
  parameter int CNT_W  = 4,
  parameter int TW     = 4,
  parameter int AP_BIT = 10,
  localparam int WORD_W = 5 + CNT_W + AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wr,
  input  logic [WORD_W-1:0] cmd_word,
  input  logic [TW-1:0]     trc_m1,
  input  logic [TW-1:0]     trp_m1,
  input  logic [TW-1:0]     tmrd_m1,
  output logic              busy,
  output logic              overrun,
  output logic              sd_cke,
  output logic [1:0]        sd_cs_n,
  output logic              sd_ras_n,
  output logic              sd_cas_n,
  output logic              sd_we_n,
  output logic [AW-1:0]     sd_addr,
  output logic [BA_W-1:0]   sd_ba
);

  localparam int T_LSB = 3;
  localparam int C_LSB = 5;
  localparam int D_LSB = C_LSB + CNT_W;

  // reset: asserted asynchronously, released on the clock
  logic [1:0] rsync_q;
  logic       rst_ni;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= '0;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ni = rsync_q[1];

  // decode of the incoming word
  logic             dec_ok, dec_strobe;
  rcw_t             dec_rcw;
  cke_act_e         dec_cke;
  wait_sel_e        dec_wsel;
  logic [AW-1:0]    dec_addr;
  logic [CNT_W-1:0] dec_reps;

  sdcmd_decode #(.AW(AW), .CNT_W(CNT_W), .AP_BIT(AP_BIT)) u_dec (
    .mode_i   (cmd_word[2:0]),
    .tgt_i    (cmd_word[T_LSB+1:T_LSB]),
    .cnt_i    (cmd_word[C_LSB+CNT_W-1:C_LSB]),
    .data_i   (cmd_word[D_LSB+AW-1:D_LSB]),
    .ok_o     (dec_ok),
    .strobe_o (dec_strobe),
    .rcw_o    (dec_rcw),
    .cke_o    (dec_cke),
    .wsel_o   (dec_wsel),
    .addr_o   (dec_addr),
    .reps_o   (dec_reps)
  );

  // state
  logic             busy_q, busy_d;
  logic             ovr_q, ovr_d;
  logic             cke_q, cke_d;
  logic [1:0]       csn_q, csn_d;
  rcw_t             rcw_q, rcw_d;
  logic [AW-1:0]    addr_q, addr_d;
  logic [CNT_W-1:0] reps_q, reps_d;
  wait_sel_e        wsel_q, wsel_d;
  rcw_t             hold_rcw_q, hold_rcw_d;
  logic [1:0]       hold_cs_q, hold_cs_d;
  logic [AW-1:0]    hold_addr_q, hold_addr_d;

  logic          accept, reissue, finish;
  logic          tmr_load, tmr_zero;
  wait_sel_e     load_sel;
  logic [TW-1:0] load_val;

  sdcmd_timer #(.TW(TW)) u_tmr (
    .clk        (clk),
    .rst_n      (rst_ni),
    .load_i     (tmr_load),
    .load_val_i (load_val),
    .zero_o     (tmr_zero)
  );

  always_comb begin
    accept   = cmd_wr && !busy_q && dec_ok;
    reissue  = busy_q && tmr_zero && (reps_q > CNT_W'(1));
    finish   = busy_q && tmr_zero && (reps_q <= CNT_W'(1));
    tmr_load = accept || reissue;
    load_sel = accept ? dec_wsel : wsel_q;
    case (load_sel)
      WT_RP:   load_val = trp_m1;
      WT_RC:   load_val = trc_m1;
      WT_MRD:  load_val = tmrd_m1;
      default: load_val = '0;
    endcase
  end

  always_comb begin
    busy_d      = busy_q;
    ovr_d       = ovr_q | (cmd_wr & busy_q);
    cke_d       = cke_q;
    csn_d       = 2'b11;
    rcw_d       = RCW_NOP;
    addr_d      = '0;
    reps_d      = reps_q;
    wsel_d      = wsel_q;
    hold_rcw_d  = hold_rcw_q;
    hold_cs_d   = hold_cs_q;
    hold_addr_d = hold_addr_q;
    if (accept) begin
      busy_d      = 1'b1;
      reps_d      = dec_reps;
      wsel_d      = dec_wsel;
      hold_rcw_d  = dec_rcw;
      hold_cs_d   = cmd_word[T_LSB+1:T_LSB];
      hold_addr_d = dec_addr;
      if (dec_strobe) begin
        csn_d  = ~cmd_word[T_LSB+1:T_LSB];
        rcw_d  = dec_rcw;
        addr_d = dec_addr;
      end
      case (dec_cke)
        CKE_SET: cke_d = 1'b1;
        CKE_CLR: cke_d = 1'b0;
        default: ;
      endcase
    end else if (reissue) begin
      reps_d = reps_q - 1'b1;
      csn_d  = ~hold_cs_q;
      rcw_d  = hold_rcw_q;
      addr_d = hold_addr_q;
    end else if (finish) begin
      busy_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q      <= 1'b0;
      ovr_q       <= 1'b0;
      cke_q       <= 1'b0;
      csn_q       <= 2'b11;
      rcw_q       <= RCW_NOP;
      addr_q      <= '0;
      reps_q      <= '0;
      wsel_q      <= WT_NONE;
      hold_rcw_q  <= RCW_NOP;
      hold_cs_q   <= '0;
      hold_addr_q <= '0;
    end else begin
      busy_q  <= busy_d;
      ovr_q   <= ovr_d;
      cke_q   <= cke_d;
      csn_q   <= csn_d;
      rcw_q   <= rcw_d;
      addr_q  <= addr_d;
      reps_q  <= reps_d;
      wsel_q  <= wsel_d;
      if (accept) begin
        hold_rcw_q  <= hold_rcw_d;
        hold_cs_q   <= hold_cs_d;
        hold_addr_q <= hold_addr_d;
      end
    end
  end

  assign busy     = busy_q;
  assign overrun  = ovr_q;
  assign sd_cke   = cke_q;
  assign sd_cs_n  = csn_q;
  assign sd_ras_n = rcw_q.ras_n;
  assign sd_cas_n = rcw_q.cas_n;
  assign sd_we_n  = rcw_q.we_n;
  assign sd_addr  = addr_q;
  assign sd_ba    = '0;

  // R9: pins rest at NOP while idle
  p_idle_nop_r9: assert property (@(posedge clk) disable iff (!rst_ni)
    !busy |-> (sd_cs_n == 2'b11 && sd_ras_n && sd_cas_n && sd_we_n));

  // R3: precharge-all encoding always carries the all-banks address bit
  p_pall_ap_r3: assert property (@(posedge clk) disable iff (!rst_ni)
    (sd_cs_n != 2'b11 && !sd_ras_n && sd_cas_n && !sd_we_n) |-> sd_addr[AP_BIT]);

  // R5: load mode goes out with bank address zero
  p_lmr_bank_r5: assert property (@(posedge clk) disable iff (!rst_ni)
    (sd_cs_n != 2'b11 && !sd_ras_n && !sd_cas_n && !sd_we_n) |-> (sd_ba == '0));

  // R6: CKE moves only after an accepted write
  p_cke_source_r6: assert property (@(posedge clk) disable iff (!rst_ni)
    (sd_cke != $past(sd_cke)) |-> $past(cmd_wr && !busy_q));

  // R10: a write during busy sets overrun, which then holds
  p_ovr_set_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && busy) |=> overrun);
  p_ovr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_ni)
    overrun |=> overrun);

  // R11: a dropped word never raises busy
  p_drop_r11: assert property (@(posedge clk) disable iff (!rst_ni)
    (cmd_wr && !busy && !dec_ok) |=> !busy);

endmodule

// File: tb/sdram_cmd_engine_bench.sv
module sdram_cmd_engine_bench;

  localparam int AW = 13;
  localparam int WORD_W = 22;

  logic              clk;
  logic              rst_n;
  logic              cmd_wr;
  logic [WORD_W-1:0] cmd_word;
  logic [3:0]        trc_m1, trp_m1, tmrd_m1;
  logic              busy, overrun, sd_cke;
  logic [1:0]        sd_cs_n;
  logic              sd_ras_n, sd_cas_n, sd_we_n;
  logic [AW-1:0]     sd_addr;
  logic [1:0]        sd_ba;

  sdram_cmd_engine u_sdram_cmd_engine (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_word(cmd_word),
    .trc_m1(trc_m1), .trp_m1(trp_m1), .tmrd_m1(tmrd_m1),
    .busy(busy), .overrun(overrun), .sd_cke(sd_cke), .sd_cs_n(sd_cs_n),
    .sd_ras_n(sd_ras_n), .sd_cas_n(sd_cas_n), .sd_we_n(sd_we_n),
    .sd_addr(sd_addr), .sd_ba(sd_ba)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  function automatic logic [WORD_W-1:0] mkw(input logic [2:0] m, input logic [1:0] t,
                                             input logic [3:0] c, input logic [12:0] d);
    return {d, c, t, m};
  endfunction

  function automatic string req_of(input logic [2:0] m);
    case (m)
      3'd0: return "R8";
      3'd1: return "R6";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5";
      default: return "R7";
    endcase
  endfunction

  typedef struct packed {
    logic [WORD_W-1:0] word;
    logic [1:0]        csn;
    logic [2:0]        rcw;
    logic [12:0]       addr;
    logic              cke;
    logic [7:0]        pulses;
    logic [7:0]        blen;
  } vec_t;

  // timings used: tRC=6, tRP=3, tMRD=2 cycles
  localparam vec_t VEC [10] = '{
    '{mkw(3'd1, 2'b01, 4'd0, 13'h0),   2'b11, 3'b111, 13'h000, 1'b1, 8'd0, 8'd1},  // R6
    '{mkw(3'd2, 2'b11, 4'd0, 13'h0),   2'b00, 3'b010, 13'h400, 1'b1, 8'd1, 8'd3},  // R3 R2
    '{mkw(3'd3, 2'b01, 4'd8, 13'h0),   2'b10, 3'b001, 13'h000, 1'b1, 8'd8, 8'd48}, // R4
    '{mkw(3'd4, 2'b10, 4'd0, 13'h230), 2'b01, 3'b000, 13'h230, 1'b1, 8'd1, 8'd2},  // R5
    '{mkw(3'd3, 2'b10, 4'd0, 13'h0),   2'b01, 3'b001, 13'h000, 1'b1, 8'd1, 8'd6},  // R4 count 0
    '{mkw(3'd0, 2'b11, 4'd0, 13'h0),   2'b11, 3'b111, 13'h000, 1'b1, 8'd0, 8'd1},  // R8
    '{mkw(3'd6, 2'b01, 4'd0, 13'h0),   2'b11, 3'b111, 13'h000, 1'b0, 8'd0, 8'd1},  // R7
    '{mkw(3'd1, 2'b10, 4'd0, 13'h0),   2'b11, 3'b111, 13'h000, 1'b1, 8'd0, 8'd1},  // R6
    '{mkw(3'd5, 2'b11, 4'd0, 13'h0),   2'b00, 3'b001, 13'h000, 1'b0, 8'd1, 8'd6},  // R7
    '{mkw(3'd0, 2'b01, 4'd0, 13'h0),   2'b11, 3'b111, 13'h000, 1'b0, 8'd0, 8'd1}   // R8
  };

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic run(input vec_t v, input int trc_cyc);
    string r;
    int pulses, blen, last;
    r = req_of(v.word[2:0]);
    pulses = 0; blen = 0; last = 0;
    @(negedge clk);
    cmd_word = v.word;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(sd_cke == v.cke, r, "cke", sd_cke, v.cke);
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      blen++;
      if (sd_cs_n != 2'b11) begin
        if (pulses == 0) begin
          check(sd_cs_n == v.csn, "R2", "cs_n", sd_cs_n, v.csn);
          check({sd_ras_n, sd_cas_n, sd_we_n} == v.rcw, r, "rcw",
                {sd_ras_n, sd_cas_n, sd_we_n}, v.rcw);
          check(sd_addr == v.addr, r, "addr", sd_addr, v.addr);
        end else begin
          check(i - last == trc_cyc, r, "gap", i - last, trc_cyc);
        end
        last = i;
        pulses++;
      end
      @(negedge clk);
    end
    check(pulses == int'(v.pulses), r, "pulses", pulses, v.pulses);
    check(blen == int'(v.blen), r, "busy_len", blen, v.blen);
    check(sd_cs_n == 2'b11 && {sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R9", "idle_pins",
          {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n}, 5'h1f);
  endtask

  task automatic drop_word(input logic [WORD_W-1:0] w);
    @(negedge clk);
    cmd_word = w;
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_wr = 1'b0;
    check(!busy, "R11", "busy", busy, 0);
    check(sd_cs_n == 2'b11, "R11", "cs_n", sd_cs_n, 2'b11);
    check(!overrun, "R11", "overrun", overrun, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      failures++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int pulses;
    bit wrong;
    rst_n = 1'b1;
    cmd_wr = 1'b0;
    cmd_word = '0;
    trc_m1 = 4'd5;
    trp_m1 = 4'd2;
    tmrd_m1 = 4'd1;
    #1 rst_n = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!sd_cke, "R1", "cke", sd_cke, 0);
    check(sd_cs_n == 2'b11, "R1", "cs_n", sd_cs_n, 2'b11);
    check({sd_ras_n, sd_cas_n, sd_we_n} == 3'b111, "R1", "rcw",
          {sd_ras_n, sd_cas_n, sd_we_n}, 3'b111);
    check(sd_addr == '0 && !busy && !overrun, "R1", "addr_busy_ovr",
          {sd_addr, busy, overrun}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R11 dropped words
    drop_word(mkw(3'd2, 2'b00, 4'd0, 13'h0));
    drop_word(mkw(3'd7, 2'b11, 4'd0, 13'h0));

    // power-up order and low-power modes
    for (int k = 0; k < 10; k++) run(VEC[k], 6);

    // R4 back-to-back refreshes with a one-cycle row cycle
    trc_m1 = 4'd0;
    run('{mkw(3'd3, 2'b11, 4'd3, 13'h0), 2'b00, 3'b001, 13'h0, 1'b0, 8'd3, 8'd3}, 1);
    trc_m1 = 4'd5;

    // R10 write during a refresh burst
    pulses = 0;
    wrong = 1'b0;
    @(negedge clk);
    cmd_word = mkw(3'd3, 2'b01, 4'd2, 13'h0);
    cmd_wr = 1'b1;
    @(negedge clk);
    cmd_word = mkw(3'd2, 2'b11, 4'd0, 13'h0);
    for (int i = 0; i < 400; i++) begin
      if (!busy) break;
      if (sd_cs_n != 2'b11) begin
        pulses++;
        if (sd_cs_n != 2'b10 || {sd_ras_n, sd_cas_n, sd_we_n} != 3'b001) wrong = 1'b1;
      end
      @(negedge clk);
      cmd_wr = 1'b0;
    end
    check(pulses == 2, "R10", "pulses", pulses, 2);
    check(!wrong, "R10", "foreign_pulse", wrong, 0);
    check(overrun, "R10", "overrun", overrun, 1);
    repeat (5) @(negedge clk);
    check(overrun && !busy, "R10", "sticky", {overrun, busy}, 2'b10);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule